// File: doc/BRIEF.md
# Three-Input Bitwise Lookup Unit

This unit evaluates any Boolean function of three inputs across a 64-bit word. For every bit position it forms a 3-bit index from the matching bits of three operands (T, A and B) and returns the entry that the index selects in an 8-entry truth table. T is the operand that is also the destination in the surrounding datapath, and it supplies the most significant index bit. One table byte can therefore express majority, three-way XOR, a bitwise multiplexer or any of the other 256 three-input functions.

The truth table comes from one of two places. It can be an 8-bit immediate, or it can be the low byte of a fourth register operand, chosen by a select flag. A 2-bit mode picks the kind of evaluation. Bitwise mode works on every bit independently. Whole-word mode first collapses each operand to a single zero/nonzero bit, looks up the table once and returns that one bit zero-extended to the full width. The other two mode codes are reserved and return zero. The lookup logic is purely combinational. The answer is captured in one output register, so it can sit in a single execute stage.

Top module: `lut3_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` is loaded with zero. It still reads zero in the first cycle after reset is released.
- R2: In bitwise mode (`mode` = 2'b00), result bit i equals table bit k, where k = {T[i], A[i], B[i]}. T[i] is index bit 2, A[i] is bit 1 and B[i] is bit 0.
- R3: When `tbl_from_reg` is 0, the table is `imm_tbl`, and `reg_tbl` has no effect on `result`.
- R4: When `tbl_from_reg` is 1, the table is `reg_tbl[7:0]`. Bits [63:8] of `reg_tbl` and all of `imm_tbl` have no effect on `result`.
- R5: In whole-word mode (`mode` = 2'b01), each operand is reduced to 1 if any of its bits is set and to 0 otherwise. `result[0]` is the table bit at {T≠0, A≠0, B≠0}, and `result[63:1]` is zero.
- R6: Mode codes 2'b10 and 2'b11 produce an all-zero `result`.
- R7: `result` changes only at a rising clock edge. It shows the function of the inputs sampled at the previous edge, which is one cycle of latency.
- R8: In bitwise mode, table 0xE8 yields the bitwise majority of T, A and B, 0x96 yields T^A^B, and 0xCA yields T ? A : B for each bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_t | input | 64 | Destination-side operand, supplies index bit 2 |
| op_a | input | 64 | Operand supplying index bit 1 |
| op_b | input | 64 | Operand supplying index bit 0 |
| imm_tbl | input | 8 | Immediate truth table |
| reg_tbl | input | 64 | Register operand whose low byte is the truth table |
| tbl_from_reg | input | 1 | 1 selects `reg_tbl[7:0]` as the table, 0 selects `imm_tbl` |
| mode | input | 2 | 00 bitwise, 01 whole-word, 10 and 11 reserved |
| result | output | 64 | Registered lookup result |

## Verification
Every result of this block is due exactly one rising edge after its operands, table and mode are applied. This holds in bitwise, whole-word and reserved modes alike. The bench changes inputs on a falling edge and reads `result` on the next falling edge, half a period after the capturing edge. One directed check reads `result` just after new inputs are applied and before the next rising edge, and requires the previous answer to still be present. The embedded properties look back one cycle with `$past` and ignore the first cycle after reset, because the output register was still being cleared then.

// File: rtl/lut3_pkg.sv
package lut3_pkg;

    localparam int DATA_W_DEF = 64;
    localparam int TBL_W      = 8;
    localparam int IDX_W      = $clog2(TBL_W);

    typedef enum logic [1:0] {
        LM_BITWISE = 2'b00,
        LM_WORD    = 2'b01,
        LM_RSV_A   = 2'b10,
        LM_RSV_B   = 2'b11
    } lut_mode_e;

    typedef struct packed {
        logic t;
        logic a;
        logic b;
    } lut_idx_s;

    function automatic logic lut_pick(input logic [TBL_W-1:0] tbl, input lut_idx_s idx);
        return tbl[idx];
    endfunction

endpackage

// File: rtl/lut3_table_sel.sv
module lut3_table_sel
    import lut3_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic [TBL_W-1:0]  imm_tbl,
    input  logic [DATA_W-1:0] reg_tbl,
    input  logic              from_reg,
    output logic [TBL_W-1:0]  tbl
);
    logic unused_reg_hi;
    assign unused_reg_hi = ^reg_tbl[DATA_W-1:TBL_W];

    always_comb begin
        if (from_reg) tbl = reg_tbl[TBL_W-1:0];
        else          tbl = imm_tbl;
    end
endmodule

// File: rtl/lut3_bitwise.sv
module lut3_bitwise
    import lut3_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic [DATA_W-1:0] op_t,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [TBL_W-1:0]  tbl,
    output logic [DATA_W-1:0] res
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        lut_idx_s idx;
        assign idx.t  = op_t[i];
        assign idx.a  = op_a[i];
        assign idx.b  = op_b[i];
        assign res[i] = lut_pick(tbl, idx);
    end
endmodule

// File: rtl/lut3_wordwise.sv
module lut3_wordwise
    import lut3_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic [DATA_W-1:0] op_t,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [TBL_W-1:0]  tbl,
    output logic [DATA_W-1:0] res
);
    lut_idx_s idx;

    always_comb begin
        idx.t = |op_t;
        idx.a = |op_a;
        idx.b = |op_b;
        res   = '0;
        res[0] = lut_pick(tbl, idx);
    end
endmodule

// File: rtl/lut3_unit.sv
module lut3_unit
    import lut3_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] op_t,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [TBL_W-1:0]  imm_tbl,
    input  logic [DATA_W-1:0] reg_tbl,
    input  logic              tbl_from_reg,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] result
);
    logic [TBL_W-1:0]  tbl;
    logic [DATA_W-1:0] bit_res;
    logic [DATA_W-1:0] word_res;
    logic [DATA_W-1:0] nxt_res;
    lut_mode_e         mode_e;

    assign mode_e = lut_mode_e'(mode);

    lut3_table_sel #(.DATA_W(DATA_W)) u_sel (
        .imm_tbl (imm_tbl),
        .reg_tbl (reg_tbl),
        .from_reg(tbl_from_reg),
        .tbl     (tbl)
    );

    lut3_bitwise #(.DATA_W(DATA_W)) u_bit (
        .op_t(op_t), .op_a(op_a), .op_b(op_b), .tbl(tbl), .res(bit_res)
    );

    lut3_wordwise #(.DATA_W(DATA_W)) u_word (
        .op_t(op_t), .op_a(op_a), .op_b(op_b), .tbl(tbl), .res(word_res)
    );

    always_comb begin
        unique case (mode_e)
            LM_BITWISE: nxt_res = bit_res;
            LM_WORD:    nxt_res = word_res;
            default:    nxt_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) result <= '0;
        else     result <= nxt_res;
    end

    // R1: output is clear in the first cycle after reset is released
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (result == '0));

    // R6: reserved modes give zero
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode[1])) |-> (result == '0));

    // R5: whole-word mode leaves only bit 0 possibly set
    a_r5_word_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode == 2'b01)) |-> (result[DATA_W-1:1] == '0));

    // R3: an all-ones immediate table gives all ones in bitwise mode
    a_r3_imm_all_ones: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode == 2'b00 && !tbl_from_reg && imm_tbl == 8'hFF))
        |-> (result == '1));

    // R4: register table with a zero low byte gives zero whatever the upper bits hold
    a_r4_reg_low_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode == 2'b00 && tbl_from_reg && reg_tbl[7:0] == 8'h00))
        |-> (result == '0));

    // R7: output holds while nothing has been captured since the last edge
    a_r7_stable_inputs: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(op_t) && $stable(op_a) && $stable(op_b) &&
         $stable(imm_tbl) && $stable(reg_tbl) && $stable(tbl_from_reg) &&
         $stable(mode)) |=> $stable(result));
endmodule

// File: tb/sim_lut3_unit.sv
module sim_lut3_unit;
    typedef struct packed {
        logic [63:0] t;
        logic [63:0] a;
        logic [63:0] b;
    } vec_s;

    localparam int NVEC = 6;
    localparam vec_s VECS [NVEC] = '{
        '{t: 64'h0000_0000_0000_0000, a: 64'h0000_0000_0000_0000, b: 64'h0000_0000_0000_0000},
        '{t: 64'hFFFF_FFFF_FFFF_FFFF, a: 64'h0000_0000_0000_0000, b: 64'hFFFF_FFFF_FFFF_FFFF},
        '{t: 64'hF0F0_F0F0_F0F0_F0F0, a: 64'hCCCC_CCCC_CCCC_CCCC, b: 64'hAAAA_AAAA_AAAA_AAAA},
        '{t: 64'h0123_4567_89AB_CDEF, a: 64'hFEDC_BA98_7654_3210, b: 64'hDEAD_BEEF_CAFE_F00D},
        '{t: 64'h8000_0000_0000_0001, a: 64'h7FFF_FFFF_FFFF_FFFE, b: 64'h5555_0000_AAAA_FFFF},
        '{t: 64'h1357_9BDF_2468_ACE0, a: 64'h0F1E_2D3C_4B5A_6978, b: 64'hC3C3_3C3C_A5A5_5A5A}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] op_t, op_a, op_b, reg_tbl;
    logic [7:0]  imm_tbl;
    logic        tbl_from_reg;
    logic [1:0]  mode;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lut3_unit u0 (
        .clk(clk), .rst(rst), .op_t(op_t), .op_a(op_a), .op_b(op_b),
        .imm_tbl(imm_tbl), .reg_tbl(reg_tbl), .tbl_from_reg(tbl_from_reg),
        .mode(mode), .result(result)
    );

    function automatic logic [63:0] model_bitwise(logic [63:0] t, logic [63:0] a,
                                                  logic [63:0] b, logic [7:0] tb);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) begin
            int k;
            k = 4 * int'(t[i]) + 2 * int'(a[i]) + int'(b[i]);
            r[i] = (tb >> k) & 8'd1;
        end
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(logic [63:0] t, logic [63:0] a, logic [63:0] b,
                         logic [7:0] it, logic [63:0] rt, logic src, logic [1:0] md);
        @(negedge clk);
        op_t = t; op_a = a; op_b = b;
        imm_tbl = it; reg_tbl = rt; tbl_from_reg = src; mode = md;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        op_t = 64'hFFFF_FFFF_FFFF_FFFF; op_a = '1; op_b = '1;
        imm_tbl = 8'hFF; reg_tbl = '1; tbl_from_reg = 1'b0; mode = 2'b00;
        repeat (3) @(negedge clk);
        check("R1 reset holds zero", result, 64'd0);
        rst = 1'b0;
        op_t = '0; op_a = '0; op_b = '0; imm_tbl = 8'h00;
        check("R1 zero right after release", result, 64'd0);

        // Vector table walk: R8 named functions plus R2 reference, imm and reg forms
        for (int v = 0; v < NVEC; v++) begin
            logic [63:0] t, a, b;
            t = VECS[v].t; a = VECS[v].a; b = VECS[v].b;
            apply(t, a, b, 8'hE8, 64'd0, 1'b0, 2'b00);
            check("R8 majority 0xE8", result, (t & a) | (t & b) | (a & b));
            apply(t, a, b, 8'h96, 64'd0, 1'b0, 2'b00);
            check("R8 xor3 0x96", result, t ^ a ^ b);
            apply(t, a, b, 8'h00, 64'h5A5A_0000_0000_00CA, 1'b1, 2'b00);
            check("R8 mux 0xCA reg form", result, (t & a) | (~t & b));
            apply(t, a, b, 8'h3D, 64'd0, 1'b0, 2'b00);
            check("R2 reference table 0x3D", result, model_bitwise(t, a, b, 8'h3D));
        end

        // R2: single-entry tables locate each index bit
        for (int k = 0; k < 8; k++) begin
            logic [7:0] one;
            one = 8'd1 << k;
            apply(64'hF0F0_F0F0_F0F0_F0F0, 64'hCCCC_CCCC_CCCC_CCCC,
                  64'hAAAA_AAAA_AAAA_AAAA, one, 64'd0, 1'b0, 2'b00);
            check("R2 one-hot table index order", result,
                  model_bitwise(64'hF0F0_F0F0_F0F0_F0F0, 64'hCCCC_CCCC_CCCC_CCCC,
                                64'hAAAA_AAAA_AAAA_AAAA, one));
        end

        // R3: register operand ignored in immediate form
        apply(64'h00FF, 64'h0F0F, 64'h3333, 8'hF0, 64'hFFFF_FFFF_FFFF_FF0F, 1'b0, 2'b00);
        check("R3 reg_tbl ignored in imm form", result, 64'h0000_0000_0000_00FF);

        // R4: upper register bits and immediate ignored in register form
        apply(64'h00FF, 64'h0F0F, 64'h3333, 8'hFF, 64'hFFFF_FFFF_FFFF_FFF0, 1'b1, 2'b00);
        check("R4 only low byte of reg_tbl used", result, 64'h0000_0000_0000_00FF);
        apply(64'h00FF, 64'h0F0F, 64'h3333, 8'hFF, 64'h1234_5678_9ABC_DE00, 1'b1, 2'b00);
        check("R4 zero low byte gives zero", result, 64'd0);

        // R5: whole-word mode
        apply(64'd0, 64'h8000_0000_0000_0000, 64'd0, 8'h04, 64'd0, 1'b0, 2'b01);
        check("R5 word index 010 selects bit 2", result, 64'd1);
        apply(64'd0, 64'h8000_0000_0000_0000, 64'd0, 8'hFB, 64'd0, 1'b0, 2'b01);
        check("R5 word index 010 clear bit", result, 64'd0);
        apply(64'h10, 64'h1, 64'h4000, 8'h80, 64'd0, 1'b0, 2'b01);
        check("R5 word all nonzero index 7", result, 64'd1);
        apply(64'd0, 64'd0, 64'd0, 8'h00, 64'h01, 1'b1, 2'b01);
        check("R5 word all zero index 0 reg form", result, 64'd1);

        // R6: reserved modes
        apply(64'h1234, 64'h5678, 64'h9ABC, 8'hFF, 64'hFF, 1'b0, 2'b10);
        check("R6 mode 10 zero", result, 64'd0);
        apply(64'h1234, 64'h5678, 64'h9ABC, 8'hFF, 64'hFF, 1'b1, 2'b11);
        check("R6 mode 11 zero", result, 64'd0);

        // R7: one cycle of latency
        apply(64'd0, 64'd0, 64'd0, 8'hFF, 64'd0, 1'b0, 2'b00);
        check("R7 result after one edge", result, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        imm_tbl = 8'h00;
        #1;
        check("R7 result unchanged before edge", result, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        check("R7 new result after edge", result, 64'd0);

        // R1: reset in mid-run clears output
        apply(64'd0, 64'd0, 64'd0, 8'hFF, 64'd0, 1'b0, 2'b00);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears mid-run", result, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 resumes after reset", result, 64'hFFFF_FFFF_FFFF_FFFF);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule